// File: doc/BRIEF.md
# Transmit Queue Interrupt Controller

This block collects interrupt sources for an isochronous transmit path whose data comes from a 1024-quadlet queue. Three sources come from the queue fill count: the block compares it against fixed levels of 512, 768 and 924 quadlets. Seven more sources arrive as single-cycle pulses from the transmit logic. These are SYT sent, payload sent or dropped, data-block-count sync loss, input error, lost cycle, bank full and bank empty.

Every source latches into a sticky status bit. The bit stays set until the host acknowledges it, even when the transmit logic has already recovered. An enable register selects which status bits drive the single registered interrupt line. Both registers sit on a simple 32-bit register bus: writes take effect at the clock edge and reads are combinational.

Top module: `txq_irq_top`

## Requirements
- R1: After reset, the status register, the enable register and `irqOut` are all zero.
- R2: The status register is at byte offset 0x2C and the enable register is at 0x30. Only bits 9..0 exist, and bits 31..10 always read zero. Any other offset reads 0x00000000.
- R3: A level bit sets when the fill count crosses a level upward. This means the previous cycle's count was below the level and the current count is at or above it. Bit 9 uses 924 quadlets, bit 8 uses 768 and bit 7 uses 512. The bit is visible on the bus in the cycle after the edge that samples the crossing count.
- R4: A fill count that stays at or above a level does not set that level bit again after a clear. It sets again only after the count falls below the level and then rises to it.
- R5: A one-cycle pulse sets its status bit. The mapping is: `evSytSent` bit 6, `evPayloadDone` bit 5, `evDbcLoss` bit 4, `evInputErr` bit 3, `evLostCycle` bit 2, `evBankFull` bit 1, `evBankEmpty` bit 0.
- R6: A status bit stays set until the host writes 1 to it at offset 0x2C, which clears it. Writing 0 to a bit leaves it unchanged.
- R7: If an event and a host clear reach the same bit in the same cycle, the bit ends up set.
- R8: A status bit latches whether or not its enable bit is set.
- R9: `irqOut` equals the OR of (status AND enable) as it stood one cycle earlier.
- R10: Writes to enable bits 31..10 are ignored, and those bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| fillCount | input | 11 | Current queue occupancy in quadlets (0..1024) |
| evSytSent | input | 1 | SYT sent pulse |
| evPayloadDone | input | 1 | Payload sent or dropped pulse |
| evDbcLoss | input | 1 | Data-block-count sync loss pulse |
| evInputErr | input | 1 | Input error pulse |
| evLostCycle | input | 1 | Lost cycle pulse |
| evBankFull | input | 1 | Bank full pulse |
| evBankEmpty | input | 1 | Bank empty pulse |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The bench tests the exact level boundaries: 511 against 512, 767 against 768 and 923 against 924. A comparator that is off by one would set one step late or one step early. After a clear, the bench holds the fill count above each level. Level-sensitive detection would then set the bit again at once. The bench also fires an event in the same cycle as its clear; a design where the clear wins would lose that event. It pulses sources that are disabled and checks that their status still latches while `irqOut` stays low. It checks that `irqOut` rises exactly one cycle after status and enable first overlap, which catches a missing or doubled output register.

// File: rtl/txq_irq_pkg.sv
package txq_irq_pkg;
  localparam int STAT_BITS  = 10;
  localparam int PULSE_BITS = 7;
  localparam int LEVEL_CNT  = 3;

  typedef struct packed {
    logic statWr;
    logic enWr;
    logic statRd;
    logic enRd;
  } hostStrobe_t;
endpackage

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl
  import txq_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int STAT_OFF = 'h2C,
  parameter int EN_OFF   = 'h30
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output hostStrobe_t       strobe
);
  logic hitStat;
  logic hitEn;

  assign hitStat = (busAddr == ADDR_W'(STAT_OFF));
  assign hitEn   = (busAddr == ADDR_W'(EN_OFF));

  always_comb begin
    strobe.statWr = busWrEn & hitStat;
    strobe.enWr   = busWrEn & hitEn;
    strobe.statRd = hitStat;
    strobe.enRd   = hitEn;
  end
endmodule

// File: rtl/txq_irq_dp.sv
module txq_irq_dp
  import txq_irq_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int DATA_W    = 32,
  parameter int LVL_HALF  = 512,
  parameter int LVL_MID   = 768,
  parameter int LVL_HIGH  = 924
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hostStrobe_t           strobe,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [CNT_W-1:0]      fillCount,
  input  logic [PULSE_BITS-1:0] pulseEv,
  output logic [STAT_BITS-1:0]  statusQ,
  output logic [STAT_BITS-1:0]  enableQ,
  output logic                  irqOut
);
  localparam logic [LEVEL_CNT*CNT_W-1:0] LEVELS =
    {CNT_W'(LVL_HIGH), CNT_W'(LVL_MID), CNT_W'(LVL_HALF)};
  localparam int PAD_W = DATA_W - STAT_BITS;

  logic [CNT_W-1:0]     prevCount;
  logic [LEVEL_CNT-1:0] crossEv;
  logic [STAT_BITS-1:0] setMask;
  logic [STAT_BITS-1:0] clrMask;
  logic [STAT_BITS-1:0] statusNext;

  for (genvar g = 0; g < LEVEL_CNT; g++) begin : g_level
    localparam logic [CNT_W-1:0] LVL = LEVELS[g*CNT_W +: CNT_W];
    assign crossEv[g] = (prevCount < LVL) && (fillCount >= LVL);
  end

  assign setMask    = {crossEv, pulseEv};
  assign clrMask    = strobe.statWr ? busWrData[STAT_BITS-1:0] : '0;
  assign statusNext = (statusQ & ~clrMask) | setMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCount <= '0;
      statusQ   <= '0;
      enableQ   <= '0;
      irqOut    <= 1'b0;
    end else begin
      prevCount <= fillCount;
      statusQ   <= statusNext;
      if (strobe.enWr) enableQ <= busWrData[STAT_BITS-1:0];
      irqOut    <= |(statusQ & enableQ);
    end
  end

  always_comb begin
    busRdData = '0;
    if (strobe.statRd)    busRdData = {{PAD_W{1'b0}}, statusQ};
    else if (strobe.enRd) busRdData = {{PAD_W{1'b0}}, enableQ};
  end
endmodule

// File: rtl/txq_irq_top.sv
module txq_irq_top
  import txq_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 1024,
  parameter int STAT_OFF = 'h2C,
  parameter int EN_OFF   = 'h30,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  fillCount,
  input  logic              evSytSent,
  input  logic              evPayloadDone,
  input  logic              evDbcLoss,
  input  logic              evInputErr,
  input  logic              evLostCycle,
  input  logic              evBankFull,
  input  logic              evBankEmpty,
  output logic              irqOut
);
  localparam int LVL_HALF = DEPTH / 2;
  localparam int LVL_MID  = DEPTH - 256;
  localparam int LVL_HIGH = DEPTH - 100;

  hostStrobe_t          strobe;
  logic [STAT_BITS-1:0] statusVal;
  logic [STAT_BITS-1:0] enableVal;
  logic [PULSE_BITS-1:0] pulseEv;

  assign pulseEv = {evSytSent, evPayloadDone, evDbcLoss, evInputErr,
                    evLostCycle, evBankFull, evBankEmpty};

  txq_irq_ctrl #(.ADDR_W(ADDR_W), .STAT_OFF(STAT_OFF), .EN_OFF(EN_OFF)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  txq_irq_dp #(
    .CNT_W(CNT_W), .DATA_W(DATA_W),
    .LVL_HALF(LVL_HALF), .LVL_MID(LVL_MID), .LVL_HIGH(LVL_HIGH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .fillCount (fillCount),
    .pulseEv   (pulseEv),
    .statusQ   (statusVal),
    .enableQ   (enableVal),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/txq_irq_chk.sv
module txq_irq_chk
  import txq_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_OFF = 'h2C
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWrEn,
  input logic [DATA_W-1:0]     busWrData,
  input logic [DATA_W-1:0]     busRdData,
  input logic [PULSE_BITS-1:0] pulseEv,
  input logic [STAT_BITS-1:0]  statusVal,
  input logic [STAT_BITS-1:0]  enableVal,
  input logic                  irqOut
);
  logic                 statWrite;
  logic [STAT_BITS-1:0] clrMask;

  assign statWrite = busWrEn && (busAddr == ADDR_W'(STAT_OFF));
  assign clrMask   = statWrite ? busWrData[STAT_BITS-1:0] : '0;

  // R6: set bits not named by a clear remain set
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusVal) & ~$past(clrMask) & ~statusVal) == '0));

  // R6: a clear without a competing pulse empties the named pulse bits
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && pulseEv == '0) |=> ((statusVal[PULSE_BITS-1:0] &
      $past(busWrData[PULSE_BITS-1:0])) == '0));

  // R5, R7, R8: every pulse lands in status, even against a clear
  p_pulse_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVal[PULSE_BITS-1:0] & $past(pulseEv)) == $past(pulseEv)));

  // R9: interrupt follows status AND enable one cycle later
  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == |($past(statusVal) & $past(enableVal))));

  // R2, R10: unimplemented bits read zero
  always_comb begin
    if (rstN) begin
      p_upper_zero_r2: assert (busRdData[DATA_W-1:STAT_BITS] == '0);
    end
  end
endmodule

bind txq_irq_top txq_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFF(STAT_OFF)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .pulseEv   (pulseEv),
  .statusVal (statusVal),
  .enableVal (enableVal),
  .irqOut    (irqOut)
);

// File: tb/txq_irq_top_tb.sv
module txq_irq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h2C;
  localparam logic [7:0] A_EN   = 8'h30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [10:0] fillCount = '0;
  logic [6:0]  evBus = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_irq_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .fillCount(fillCount),
    .evSytSent(evBus[6]), .evPayloadDone(evBus[5]), .evDbcLoss(evBus[4]),
    .evInputErr(evBus[3]), .evLostCycle(evBus[2]), .evBankFull(evBus[1]),
    .evBankEmpty(evBus[0]), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic pulse(input logic [6:0] v);
    evBus = v;
    @(posedge clk); @(negedge clk);
    evBus = '0;
  endtask

  task automatic setFill(input int n);
    fillCount = 11'(n);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(A_STAT, rd); check("R1 status", rd, 0);
    readReg(A_EN, rd);   check("R1 enable", rd, 0);
    check("R1 irq", {31'b0, irqOut}, 0);

    // R10, R2: enable upper bits ignored, other offsets read zero
    writeReg(A_EN, 32'hFFFF_FFFF);
    readReg(A_EN, rd); check("R10 enable mask", rd, 32'h0000_03FF);
    readReg(8'h34, rd); check("R2 unused offset", rd, 0);
    writeReg(A_EN, 0);

    // R5, R6, R8: sweep every pulse source, disabled
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      readReg(A_STAT, rd); check("R5 pulse bit", rd, 32'(1 << i));
      check("R8 irq stays low when disabled", {31'b0, irqOut}, 0);
      writeReg(A_STAT, 0);
      readReg(A_STAT, rd); check("R6 write zero keeps", rd, 32'(1 << i));
      writeReg(A_STAT, 32'(1 << i));
      readReg(A_STAT, rd); check("R6 write one clears", rd, 0);
    end

    // R3: boundary sweep below each level, then ramp across all
    setFill(511); setFill(767); setFill(923);
    readReg(A_STAT, rd); check("R3 below levels", rd, 32'h0000_0180);
    writeReg(A_STAT, 32'h3FF);
    setFill(0);
    for (int n = 0; n <= 1024; n += 8) begin
      setFill(n);
      readReg(A_STAT, rd);
      check("R3 ramp", rd,
            {22'b0, (n >= 924), (n >= 768), (n >= 512), 7'b0});
    end

    // R4: holding above levels does not re-set
    writeReg(A_STAT, 32'h380);
    setFill(1000); setFill(1024);
    readReg(A_STAT, rd); check("R4 held above", rd, 0);
    setFill(600); setFill(800);
    readReg(A_STAT, rd); check("R4 recross mid only", rd, 32'h100);
    writeReg(A_STAT, 32'h3FF);
    setFill(923);
    readReg(A_STAT, rd); check("R3 923 below high", rd, 0);
    setFill(924);
    readReg(A_STAT, rd); check("R3 924 sets high", rd, 32'h200);
    writeReg(A_STAT, 32'h3FF);
    setFill(0);

    // R7: event and clear in the same cycle
    pulse(7'h10);
    evBus = 7'h10;
    writeReg(A_STAT, 32'h10);
    evBus = '0;
    readReg(A_STAT, rd); check("R7 set wins", rd, 32'h10);
    writeReg(A_STAT, 32'h10);

    // R9: irq one cycle after status meets enable
    writeReg(A_EN, 32'h008);
    pulse(7'h04);
    check("R8 disabled source no irq", {31'b0, irqOut}, 0);
    evBus = 7'h08;
    @(posedge clk); @(negedge clk);
    evBus = '0;
    check("R9 irq not yet", {31'b0, irqOut}, 0);
    @(posedge clk); @(negedge clk);
    check("R9 irq raised", {31'b0, irqOut}, 1);
    writeReg(A_STAT, 32'h008);
    check("R9 irq held one cycle", {31'b0, irqOut}, 1);
    @(posedge clk); @(negedge clk);
    check("R9 irq dropped", {31'b0, irqOut}, 0);
    readReg(A_STAT, rd); check("R8 disabled bit latched", rd, 32'h004);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule